// File: doc/BRIEF.md
# Pipelined Three-Tap FIR Filter

The block filters a stream of signed samples with a three-coefficient finite impulse response. Every output is the weighted sum of the newest accepted sample and the two accepted before it, with weights `a`, `b` and `c` taken from static coefficient inputs. Results are kept at full precision: the output is the input width plus the coefficient width plus two guard bits, so the sum can never wrap.

A parameter picks one of two structures. Both keep the longest combinational path to one multiplier followed by one adder. The direct structure keeps a tapped delay line on the samples. It puts one register on each of the two edges of a feed-forward cutset: the `a` product, and the partial sum of the `b` and `c` products. The transposed structure sends each new sample to all three multipliers in the same cycle. Its delay registers sit in the adder chain, so it needs no extra pipeline stage. Samples are qualified by a valid strobe. The filter's history moves only on valid samples, and the output valid strobe follows each accepted sample after a fixed latency: two cycles for the direct structure, one cycle for the transposed one.

Coefficients are meant to be changed only while the block is held in reset.

Top module: `cutset_fir3`

## Requirements
- R1: While `outValid` is high, `outSample` equals a·x(n) + b·x(n−1) + c·x(n−2). Here x(n) is the sample whose acceptance this output answers, x(n−1) and x(n−2) are the two samples accepted before it, all values are signed two's complement, and the sum is exact at SAMPLE_W+COEF_W+GUARD_W bits.
- R2: With `FORM` set to the direct structure (`FORM_DIRECT`, value 0), `outValid` rises exactly two clock edges after the edge that accepts a sample.
- R3: With `FORM` set to the transposed structure (`FORM_TRANSPOSED`, value 1), `outValid` rises exactly one clock edge after the edge that accepts a sample.
- R4: A sample presented while `inValid` is low is not taken into the filter history. It changes no later output.
- R5: Each accepted sample produces exactly one cycle of `outValid`, and outputs keep the order of their inputs. `outValid` is never high for any other reason.
- R6: While `outValid` is low, `outSample` keeps its last value.
- R7: A synchronous reset (`rst` high at a rising edge) clears all history and pipeline state. After reset, `outValid` is 0 and `outSample` is 0, and the first outputs use zero for samples older than the reset.
- R8: Samples and coefficients at the most negative value give the exact result, up to 3·2^30 for 16-bit inputs, with no overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| coefA | input | COEF_W | Weight of the newest sample (signed) |
| coefB | input | COEF_W | Weight of the sample one step older (signed) |
| coefC | input | COEF_W | Weight of the sample two steps older (signed) |
| inValid | input | 1 | Marks `inSample` as a sample to accept |
| inSample | input | SAMPLE_W | Input sample (signed) |
| outValid | output | 1 | Marks `outSample` as a new result |
| outSample | output | SAMPLE_W+COEF_W+GUARD_W | Filter result (signed, full precision) |

## Verification
One stimulus drives both structures side by side, so any difference between them shows up as a mismatch.

- A single unit impulse reads back `a`, `b` and `c` in turn, which shows that the taps are in the right order.
- A stream broken by gaps, with junk on the sample bus during the gaps, separates a design that gates its history with the valid strobe from one that samples every cycle.
- Runs of the most negative values test the guard bits.
- A reset in the middle of a stream shows whether stale history or in-flight results survive the reset.
- A long stream with random data and random valid gaps checks value, order and latency together.

// File: rtl/fir3_pkg.sv
package fir3_pkg;

  localparam int NUM_TAPS = 3;

  typedef enum logic {
    FORM_DIRECT     = 1'b0,
    FORM_TRANSPOSED = 1'b1
  } firForm_e;

  // strobes from control to datapath
  typedef struct packed {
    logic tapShift;   // advance the first delay element
    logic stageLoad;  // capture the cutset / chain registers
    logic outLoad;    // capture the output register
  } firStrobes_t;

  function automatic int formLatency(firForm_e form);
    return (form == FORM_TRANSPOSED) ? 1 : 2;
  endfunction

endpackage

// File: rtl/fir3_term.sv
module fir3_term #(
  parameter int SAMPLE_W = 16,
  parameter int COEF_W   = 16,
  parameter int ACC_W    = 34
) (
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic signed [COEF_W-1:0]   coef,
  output logic signed [ACC_W-1:0]    product
);
  localparam int PROD_W = SAMPLE_W + COEF_W;
  localparam int EXT_W  = ACC_W - PROD_W;

  logic signed [PROD_W-1:0] fullProd;

  assign fullProd = sample * coef;
  assign product  = {{EXT_W{fullProd[PROD_W-1]}}, fullProd};
endmodule

// File: rtl/fir3_ctrl.sv
module fir3_ctrl
  import fir3_pkg::*;
#(
  parameter firForm_e FORM = FORM_DIRECT
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  output firStrobes_t strobes,
  output logic        outValid
);
  localparam int LAT = formLatency(FORM);

  logic [LAT-1:0] validPipe;

  assign strobes.tapShift  = inValid;
  assign strobes.stageLoad = inValid;

  generate
    if (LAT == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) validPipe <= '0;
        else     validPipe[0] <= inValid;
      end
      assign strobes.outLoad = inValid;
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) validPipe <= '0;
        else     validPipe <= {validPipe[LAT-2:0], inValid};
      end
      assign strobes.outLoad = validPipe[LAT-2];
    end
  endgenerate

  assign outValid = validPipe[LAT-1];
endmodule

// File: rtl/fir3_datapath.sv
module fir3_datapath
  import fir3_pkg::*;
#(
  parameter firForm_e FORM     = FORM_DIRECT,
  parameter int       SAMPLE_W = 16,
  parameter int       COEF_W   = 16,
  parameter int       ACC_W    = 34
) (
  input  logic                       clk,
  input  logic                       rst,
  input  firStrobes_t                strobes,
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic signed [COEF_W-1:0]   coefA,
  input  logic signed [COEF_W-1:0]   coefB,
  input  logic signed [COEF_W-1:0]   coefC,
  output logic signed [ACC_W-1:0]    result
);
  logic signed [SAMPLE_W-1:0] mulIn   [NUM_TAPS];
  logic signed [COEF_W-1:0]   mulCoef [NUM_TAPS];
  logic signed [ACC_W-1:0]    mulOut  [NUM_TAPS];
  logic signed [ACC_W-1:0]    outReg;

  assign mulCoef[0] = coefA;
  assign mulCoef[1] = coefB;
  assign mulCoef[2] = coefC;

  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_term
    fir3_term #(
      .SAMPLE_W(SAMPLE_W),
      .COEF_W  (COEF_W),
      .ACC_W   (ACC_W)
    ) u_term (
      .sample (mulIn[t]),
      .coef   (mulCoef[t]),
      .product(mulOut[t])
    );
  end

  generate
    if (FORM == FORM_DIRECT) begin : g_direct
      // tapped delay line plus one register on each cutset edge
      logic signed [SAMPLE_W-1:0] tapOne, tapTwo;
      logic signed [ACC_W-1:0]    cutNewest, cutOlder;

      assign mulIn[0] = sample;
      assign mulIn[1] = tapOne;
      assign mulIn[2] = tapTwo;

      always_ff @(posedge clk) begin
        if (rst) begin
          tapOne    <= '0;
          tapTwo    <= '0;
          cutNewest <= '0;
          cutOlder  <= '0;
          outReg    <= '0;
        end else begin
          if (strobes.tapShift) begin
            tapOne <= sample;
            tapTwo <= tapOne;
          end
          if (strobes.stageLoad) begin
            cutNewest <= mulOut[0];
            cutOlder  <= mulOut[1] + mulOut[2];
          end
          if (strobes.outLoad) outReg <= cutNewest + cutOlder;
        end
      end
    end else begin : g_transposed
      // sample broadcast to all multipliers, delays in the adder chain
      logic signed [ACC_W-1:0] chainC, chainBC;

      assign mulIn[0] = sample;
      assign mulIn[1] = sample;
      assign mulIn[2] = sample;

      always_ff @(posedge clk) begin
        if (rst) begin
          chainC  <= '0;
          chainBC <= '0;
          outReg  <= '0;
        end else begin
          if (strobes.tapShift)  chainC  <= mulOut[2];
          if (strobes.stageLoad) chainBC <= mulOut[1] + chainC;
          if (strobes.outLoad)   outReg  <= mulOut[0] + chainBC;
        end
      end
    end
  endgenerate

  assign result = outReg;
endmodule

// File: rtl/cutset_fir3.sv
module cutset_fir3
  import fir3_pkg::*;
#(
  parameter firForm_e FORM     = FORM_DIRECT,
  parameter int       SAMPLE_W = 16,
  parameter int       COEF_W   = 16,
  parameter int       GUARD_W  = 2
) (
  input  logic                                      clk,
  input  logic                                      rst,
  input  logic signed [COEF_W-1:0]                  coefA,
  input  logic signed [COEF_W-1:0]                  coefB,
  input  logic signed [COEF_W-1:0]                  coefC,
  input  logic                                      inValid,
  input  logic signed [SAMPLE_W-1:0]                inSample,
  output logic                                      outValid,
  output logic signed [SAMPLE_W+COEF_W+GUARD_W-1:0] outSample
);
  localparam int ACC_W = SAMPLE_W + COEF_W + GUARD_W;

  firStrobes_t strobes;

  fir3_ctrl #(.FORM(FORM)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .strobes (strobes),
    .outValid(outValid)
  );

  fir3_datapath #(
    .FORM    (FORM),
    .SAMPLE_W(SAMPLE_W),
    .COEF_W  (COEF_W),
    .ACC_W   (ACC_W)
  ) u_datapath (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes),
    .sample (inSample),
    .coefA  (coefA),
    .coefB  (coefB),
    .coefC  (coefC),
    .result (outSample)
  );
endmodule

// File: rtl/fir3_checker.sv
module fir3_checker
  import fir3_pkg::*;
#(
  parameter firForm_e FORM  = FORM_DIRECT,
  parameter int       ACC_W = 34
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic             outValid,
  input logic [ACC_W-1:0] outSample
);
  localparam int LAT = formLatency(FORM);

  logic [1:0] sinceRst;

  always_ff @(posedge clk) begin
    if (rst)                 sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  // R7: state seen at the first edge after reset is cleared
  p_reset_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (sinceRst == 2'd0) |-> (!outValid && outSample == '0));

  // R5: nothing leaves before the pipeline could have filled
  p_fill_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (sinceRst < 2'(LAT)) |-> !outValid);

  // R2 / R3 / R5: output strobe tracks accepted input at fixed latency
  p_latency_r5: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 2'(LAT)) |-> (outValid == $past(inValid, LAT)));

  // R6: result holds while no new output is flagged
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (sinceRst != 2'd0 && !outValid) |-> $stable(outSample));
endmodule

bind cutset_fir3 fir3_checker #(.FORM(FORM), .ACC_W(ACC_W)) u_checker (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .outValid (outValid),
  .outSample(outSample)
);

// File: tb/tb_cutset_fir3.sv
module tb_cutset_fir3;
  import fir3_pkg::*;

  localparam int SW = 16;
  localparam int CW = 16;
  localparam int AW = SW + CW + 2;

  typedef struct {
    longint val;
    longint stamp;
    string  tag;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [CW-1:0] coefA = '0, coefB = '0, coefC = '0;
  logic inValid = 1'b0;
  logic signed [SW-1:0] inSample = '0;
  logic outValidD, outValidT;
  logic signed [AW-1:0] outD, outT;

  always #2 clk = ~clk;   // 250 MHz

  cutset_fir3 #(.FORM(FORM_DIRECT), .SAMPLE_W(SW), .COEF_W(CW), .GUARD_W(2)) dut (
    .clk(clk), .rst(rst), .coefA(coefA), .coefB(coefB), .coefC(coefC),
    .inValid(inValid), .inSample(inSample), .outValid(outValidD), .outSample(outD));

  cutset_fir3 #(.FORM(FORM_TRANSPOSED), .SAMPLE_W(SW), .COEF_W(CW), .GUARD_W(2)) dutT (
    .clk(clk), .rst(rst), .coefA(coefA), .coefB(coefB), .coefC(coefC),
    .inValid(inValid), .inSample(inSample), .outValid(outValidT), .outSample(outT));

  int     nChecks = 0;
  int     nFail   = 0;
  bit     started = 1'b0;
  bit     done    = 1'b0;
  longint cycleCnt = 0;
  longint mA, mB, mC, hist1, hist2;
  longint lastOut [2];
  item_t  qD[$];
  item_t  qT[$];

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic watch(input int which, input logic ov, input logic signed [AW-1:0] val);
    item_t  e;
    bit     have;
    longint lat;
    string  latTag;
    lat    = (which == 0) ? 2 : 1;
    latTag = (which == 0) ? "R2" : "R3";
    if (ov) begin
      have = (which == 0) ? (qD.size() > 0) : (qT.size() > 0);
      if (!have) begin
        check(1'b0, "R5", $sformatf("unexpected output form %0d", which), longint'(val), 0);
      end else begin
        e = (which == 0) ? qD.pop_front() : qT.pop_front();
        check(longint'(val) == e.val, e.tag, $sformatf("value form %0d", which),
              longint'(val), e.val);
        check(cycleCnt - e.stamp == lat, latTag, "latency", cycleCnt - e.stamp, lat);
        lastOut[which] = longint'(val);
      end
    end else begin
      check(longint'(val) == lastOut[which], "R6", $sformatf("hold form %0d", which),
            longint'(val), lastOut[which]);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && started && !done) begin
      watch(0, outValidD, outD);
      watch(1, outValidT, outT);
    end
  end

  task automatic applyReset(input longint a, input longint b, input longint c);
    @(negedge clk); #1;
    rst = 1'b1;
    inValid = 1'b0;
    qD.delete();
    qT.delete();
    hist1 = 0; hist2 = 0;
    lastOut[0] = 0; lastOut[1] = 0;
    mA = a; mB = b; mC = c;
    coefA = CW'(a); coefB = CW'(b); coefC = CW'(c);
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic send(input longint x, input string tag);
    item_t e;
    @(negedge clk); #1;
    inValid  = 1'b1;
    inSample = SW'(x);
    e.val   = mA * x + mB * hist1 + mC * hist2;
    e.stamp = cycleCnt;
    e.tag   = tag;
    qD.push_back(e);
    qT.push_back(e);
    hist2 = hist1;
    hist1 = x;
  endtask

  task automatic idle(input int n, input bit junk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      inValid  = 1'b0;
      inSample = junk ? SW'($urandom) : '0;
    end
  endtask

  task automatic drainCheck(input string tag);
    idle(6, 1'b1);
    check(qD.size() == 0, tag, "pending outputs direct", qD.size(), 0);
    check(qT.size() == 0, tag, "pending outputs transposed", qT.size(), 0);
  endtask

  initial begin
    lastOut[0] = 0; lastOut[1] = 0;
    applyReset(3, -5, 7);
    started = 1'b1;
    @(negedge clk);
    // R7: reset state at the ports
    check(outValidD == 1'b0 && outValidT == 1'b0, "R7", "valid after reset",
          longint'(outValidD) + longint'(outValidT), 0);
    check(outD == '0 && outT == '0, "R7", "result after reset",
          longint'(outD) | longint'(outT), 0);

    // R1: impulse reads back the weights in order
    send(1, "R1");
    idle(1, 1'b0);
    send(0, "R1");
    send(0, "R1");
    send(0, "R1");
    drainCheck("R5");

    // R4: gaps with junk on the sample bus
    send(100, "R4");
    idle(3, 1'b1);
    send(-200, "R4");
    idle(1, 1'b1);
    send(37, "R4");
    send(-1, "R4");
    idle(5, 1'b1);
    send(2, "R4");
    drainCheck("R4");

    // R8: most negative values everywhere
    applyReset(-32768, -32768, -32768);
    send(-32768, "R8");
    send(-32768, "R8");
    send(-32768, "R8");
    send(32767, "R8");
    drainCheck("R8");

    // R7: reset in mid-stream drops history and in-flight results
    applyReset(11, 13, -17);
    send(500, "R7");
    send(-600, "R7");
    send(700, "R7");
    applyReset(1, 1, 1);
    send(10, "R7");
    send(20, "R7");
    drainCheck("R7");

    // R1 / R5: random data with random gaps
    applyReset(-1234, 4321, 77);
    for (int i = 0; i < 400; i++) begin
      if (($urandom % 4) != 0) send(longint'($signed(SW'($urandom))), "R1");
      else idle(1, 1'b1);
    end
    drainCheck("R5");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end
endmodule